// File: doc/BRIEF.md
# Outstanding Request Buffer

A small associative table that a private cache controller uses to track requests that have left the cache and have not yet settled into a stable coherence state. Every entry records what the processor asked for (kind, size, position of the data inside the line), where the line lives (tag, set, way), the transient coherence state the controller has moved it to, a count of invalidation acknowledgements still outstanding, the word to be written and a line-sized data buffer.

The controller allocates an entry when a request misses, rewrites its state, data and acknowledgement count as messages arrive, and frees the entry when the request retires. It queries the table associatively, and the matching rule depends on the kind of message being handled: processor requests look for any live entry on the same set so that they can be held back, forwarded requests and responses need an exact tag and set match, and flushes never consult the table. A full indication tells the controller to stall new processor requests. Lookup, allocation index, full flag and the read port are combinational; all writes take effect at the next rising clock edge.

Top module: `orb_table`

## Requirements
- R1: After reset every entry is free (state code 0), `full` is 0, `alloc_idx` is 0 and no lookup mode reports a hit.
- R2: When `alloc_en` is 1 and `full` is 0, the entry at `alloc_idx`, which is always the lowest-indexed free entry, captures kind (READ=0, READ_ATOMIC=1, WRITE=2, WRITE_ATOMIC=3), tag, set, way, size (byte=0, halfword=1, word=2), word offset, byte offset, state, word and line at the next edge, and its acknowledgement count becomes 0.
- R3: `full` is 1 exactly when no entry is free; an allocation attempted while full changes no entry.
- R4: With `lk_mode` = 0 (processor request) a hit is reported when any live entry holds the same set, whatever its tag; `lk_idx` is the lowest such index.
- R5: With `lk_mode` = 1 (forward) or 2 (response) a hit needs both tag and set to match a live entry; `lk_idx` is the lowest such index.
- R6: With `lk_mode` = 3 (flush) `lk_hit` is always 0.
- R7: `free_en` returns entry `free_idx` to state 0 at the next edge, overriding any other write to that entry in the same cycle; a freed entry no longer matches and is reused by allocation.
- R8: `st_we` writes `st_val` (a transient code 1 to 13) into the state of entry `st_idx` only if that entry is live; a state write to a free entry is ignored.
- R9: `ack_load` loads `ack_val` into the acknowledgement count of `ack_idx`; `ack_dec` lowers it by one and holds at 0; load wins over decrement; `rd_ack_zero` is 1 when the count read is 0.
- R10: `word_we` and `line_we` replace the write word and line buffer of entry `dat_idx`; allocation of the same entry in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en | input | 1 | Allocate a new entry |
| alloc_kind | input | 2 | Request kind for the new entry |
| alloc_tag | input | TAG_W | Tag of the new entry |
| alloc_set | input | SET_W | Set of the new entry |
| alloc_way | input | WAY_W | Way of the new entry |
| alloc_size | input | 2 | Access size of the new entry |
| alloc_woff | input | WOFF_W | Word offset in the line |
| alloc_boff | input | BOFF_W | Byte offset in the word |
| alloc_state | input | 4 | Initial transient state |
| alloc_word | input | WORD_W | Initial write word |
| alloc_line | input | LINE_W | Initial line buffer |
| alloc_idx | output | IDX_W | Lowest free entry index |
| full | output | 1 | No entry is free |
| free_en | input | 1 | Free an entry |
| free_idx | input | IDX_W | Entry to free |
| st_we | input | 1 | State write enable |
| st_idx | input | IDX_W | Entry for state write |
| st_val | input | 4 | New transient state |
| word_we | input | 1 | Write word update enable |
| line_we | input | 1 | Line buffer update enable |
| dat_idx | input | IDX_W | Entry for word/line update |
| word_val | input | WORD_W | New write word |
| line_val | input | LINE_W | New line buffer |
| ack_load | input | 1 | Load acknowledgement count |
| ack_dec | input | 1 | Decrement acknowledgement count |
| ack_idx | input | IDX_W | Entry for count operations |
| ack_val | input | CNT_W | Count value to load |
| lk_mode | input | 2 | Lookup kind: 0 cpu, 1 forward, 2 response, 3 flush |
| lk_tag | input | TAG_W | Lookup tag |
| lk_set | input | SET_W | Lookup set |
| lk_hit | output | 1 | Lookup matched a live entry |
| lk_idx | output | IDX_W | Lowest matching entry |
| rd_idx | input | IDX_W | Read port entry select |
| rd_kind | output | 2 | Kind of selected entry |
| rd_tag | output | TAG_W | Tag of selected entry |
| rd_set | output | SET_W | Set of selected entry |
| rd_way | output | WAY_W | Way of selected entry |
| rd_size | output | 2 | Size of selected entry |
| rd_woff | output | WOFF_W | Word offset of selected entry |
| rd_boff | output | BOFF_W | Byte offset of selected entry |
| rd_state | output | 4 | State of selected entry |
| rd_invack | output | CNT_W | Acknowledgement count of selected entry |
| rd_ack_zero | output | 1 | Selected count is zero |
| rd_word | output | WORD_W | Write word of selected entry |
| rd_line | output | LINE_W | Line buffer of selected entry |

## Verification
Lookup results, the allocation index, the full flag and the read port depend combinationally on inputs and stored state, so they are due in the same cycle as their inputs; the bench drives inputs just after the falling edge and compares these outputs one nanosecond later. Every write (allocate, free, state, data, count) becomes visible on the read port and in the lookup in the cycle after the rising edge that captured it, so the bench advances its reference model at that edge and compares the read port on the following cycle. Reset release passes through a two-stage synchronizer, so the bench waits three edges after deasserting reset before issuing any operation.

// File: rtl/orb_pkg.sv
package orb_pkg;
  localparam int ST_W = 4;
  localparam logic [ST_W-1:0] ST_FREE = 4'd0;
  localparam logic [ST_W-1:0] ST_LAST = 4'd13;

  localparam logic [1:0] LK_CPU   = 2'd0;
  localparam logic [1:0] LK_FWD   = 2'd1;
  localparam logic [1:0] LK_RSP   = 2'd2;
  localparam logic [1:0] LK_FLUSH = 2'd3;

  localparam logic [1:0] KIND_RD     = 2'd0;
  localparam logic [1:0] KIND_RD_ATM = 2'd1;
  localparam logic [1:0] KIND_WR     = 2'd2;
  localparam logic [1:0] KIND_WR_ATM = 2'd3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/orb_rst_sync.sv
module orb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/orb_entry.sv
module orb_entry
  import orb_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SET_W  = 8,
  parameter int WAY_W  = 3,
  parameter int WOFF_W = 2,
  parameter int BOFF_W = 2,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_sel,
  input  logic              free_sel,
  input  logic              st_sel,
  input  logic              word_sel,
  input  logic              line_sel,
  input  logic              ld_sel,
  input  logic              dec_sel,
  input  logic [1:0]        in_kind,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [SET_W-1:0]  in_set,
  input  logic [WAY_W-1:0]  in_way,
  input  logic [1:0]        in_size,
  input  logic [WOFF_W-1:0] in_woff,
  input  logic [BOFF_W-1:0] in_boff,
  input  logic [ST_W-1:0]   in_state,
  input  logic [WORD_W-1:0] in_word,
  input  logic [LINE_W-1:0] in_line,
  input  logic [ST_W-1:0]   st_val,
  input  logic [WORD_W-1:0] word_val,
  input  logic [LINE_W-1:0] line_val,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [1:0]        q_kind,
  output logic [TAG_W-1:0]  q_tag,
  output logic [SET_W-1:0]  q_set,
  output logic [WAY_W-1:0]  q_way,
  output logic [1:0]        q_size,
  output logic [WOFF_W-1:0] q_woff,
  output logic [BOFF_W-1:0] q_boff,
  output logic [ST_W-1:0]   q_state,
  output logic [CNT_W-1:0]  q_cnt,
  output logic [WORD_W-1:0] q_word,
  output logic [LINE_W-1:0] q_line,
  output logic              live,
  output logic              cnt_zero
);
  logic [ST_W-1:0]   state_d;
  logic [CNT_W-1:0]  cnt_d;
  logic [WORD_W-1:0] word_d;
  logic [LINE_W-1:0] line_d;
  logic              meta_en;

  assign live     = (q_state != ST_FREE);
  assign cnt_zero = (q_cnt == '0);
  assign meta_en  = alloc_sel && !free_sel;

  always_comb begin
    state_d = q_state;
    cnt_d   = q_cnt;
    word_d  = q_word;
    line_d  = q_line;
    if (free_sel) begin
      state_d = ST_FREE;
    end else if (alloc_sel) begin
      state_d = in_state;
      cnt_d   = '0;
      word_d  = in_word;
      line_d  = in_line;
    end else begin
      if (st_sel && live) state_d = st_val;
      if (word_sel)       word_d  = word_val;
      if (line_sel)       line_d  = line_val;
      if (ld_sel)                     cnt_d = cnt_val;
      else if (dec_sel && !cnt_zero)  cnt_d = q_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_state <= ST_FREE;
      q_cnt   <= '0;
      q_word  <= '0;
      q_line  <= '0;
    end else begin
      q_state <= state_d;
      q_cnt   <= cnt_d;
      q_word  <= word_d;
      q_line  <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_kind <= '0;
      q_tag  <= '0;
      q_set  <= '0;
      q_way  <= '0;
      q_size <= '0;
      q_woff <= '0;
      q_boff <= '0;
    end else if (meta_en) begin
      q_kind <= in_kind;
      q_tag  <= in_tag;
      q_set  <= in_set;
      q_way  <= in_way;
      q_size <= in_size;
      q_woff <= in_woff;
      q_boff <= in_boff;
    end
  end
endmodule

// File: rtl/orb_pick.sv
module orb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     live_vec,
  output logic [IDX_W-1:0] pick_idx,
  output logic             none_free
);
  logic found;

  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!live_vec[i] && !found) begin
        pick_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    none_free = !found;
  end
endmodule

// File: rtl/orb_match.sv
module orb_match
  import orb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 16,
  parameter int SET_W = 8
) (
  input  logic [1:0]                mode,
  input  logic [TAG_W-1:0]          key_tag,
  input  logic [SET_W-1:0]          key_set,
  input  logic [N-1:0]              live_vec,
  input  logic [N-1:0][TAG_W-1:0]   tag_all,
  input  logic [N-1:0][SET_W-1:0]   set_all,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);
  logic [N-1:0] cand;
  logic         need_tag;
  logic         enabled;

  assign need_tag = (mode == LK_FWD) || (mode == LK_RSP);
  assign enabled  = (mode != LK_FLUSH);

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign cand[g] = enabled && live_vec[g] && (set_all[g] == key_set) &&
                       (!need_tag || (tag_all[g] == key_tag));
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/orb_table.sv
module orb_table
  import orb_pkg::*;
#(
  parameter int N      = 4,
  parameter int TAG_W  = 16,
  parameter int SET_W  = 8,
  parameter int WAY_W  = 3,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128,
  parameter int CNT_W  = 4,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int WOFF_W = (LINE_W / WORD_W > 1) ? $clog2(LINE_W / WORD_W) : 1,
  localparam int BOFF_W = (WORD_W / 8 > 1) ? $clog2(WORD_W / 8) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [1:0]        alloc_kind,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [SET_W-1:0]  alloc_set,
  input  logic [WAY_W-1:0]  alloc_way,
  input  logic [1:0]        alloc_size,
  input  logic [WOFF_W-1:0] alloc_woff,
  input  logic [BOFF_W-1:0] alloc_boff,
  input  logic [3:0]        alloc_state,
  input  logic [WORD_W-1:0] alloc_word,
  input  logic [LINE_W-1:0] alloc_line,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [3:0]        st_val,
  input  logic              word_we,
  input  logic              line_we,
  input  logic [IDX_W-1:0]  dat_idx,
  input  logic [WORD_W-1:0] word_val,
  input  logic [LINE_W-1:0] line_val,
  input  logic              ack_load,
  input  logic              ack_dec,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic [CNT_W-1:0]  ack_val,
  input  logic [1:0]        lk_mode,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [SET_W-1:0]  lk_set,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_kind,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [SET_W-1:0]  rd_set,
  output logic [WAY_W-1:0]  rd_way,
  output logic [1:0]        rd_size,
  output logic [WOFF_W-1:0] rd_woff,
  output logic [BOFF_W-1:0] rd_boff,
  output logic [3:0]        rd_state,
  output logic [CNT_W-1:0]  rd_invack,
  output logic              rd_ack_zero,
  output logic [WORD_W-1:0] rd_word,
  output logic [LINE_W-1:0] rd_line
);
  logic                       rst_n_s;
  logic                       alloc_fire;
  logic [N-1:0]               live_vec;
  logic [N-1:0]               zero_vec;
  logic [N-1:0][1:0]          kind_all;
  logic [N-1:0][TAG_W-1:0]    tag_all;
  logic [N-1:0][SET_W-1:0]    set_all;
  logic [N-1:0][WAY_W-1:0]    way_all;
  logic [N-1:0][1:0]          size_all;
  logic [N-1:0][WOFF_W-1:0]   woff_all;
  logic [N-1:0][BOFF_W-1:0]   boff_all;
  logic [N-1:0][ST_W-1:0]     state_all;
  logic [N-1:0][CNT_W-1:0]    cnt_all;
  logic [N-1:0][WORD_W-1:0]   word_all;
  logic [N-1:0][LINE_W-1:0]   line_all;

  orb_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  orb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .live_vec  (live_vec),
    .pick_idx  (alloc_idx),
    .none_free (full)
  );

  assign alloc_fire = alloc_en && !full;

  generate
    for (genvar g = 0; g < N; g++) begin : g_ent
      orb_entry #(
        .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W), .WOFF_W(WOFF_W),
        .BOFF_W(BOFF_W), .WORD_W(WORD_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
      ) u_entry (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .alloc_sel (alloc_fire && (alloc_idx == IDX_W'(g))),
        .free_sel  (free_en && (free_idx == IDX_W'(g))),
        .st_sel    (st_we && (st_idx == IDX_W'(g))),
        .word_sel  (word_we && (dat_idx == IDX_W'(g))),
        .line_sel  (line_we && (dat_idx == IDX_W'(g))),
        .ld_sel    (ack_load && (ack_idx == IDX_W'(g))),
        .dec_sel   (ack_dec && (ack_idx == IDX_W'(g))),
        .in_kind   (alloc_kind),
        .in_tag    (alloc_tag),
        .in_set    (alloc_set),
        .in_way    (alloc_way),
        .in_size   (alloc_size),
        .in_woff   (alloc_woff),
        .in_boff   (alloc_boff),
        .in_state  (alloc_state),
        .in_word   (alloc_word),
        .in_line   (alloc_line),
        .st_val    (st_val),
        .word_val  (word_val),
        .line_val  (line_val),
        .cnt_val   (ack_val),
        .q_kind    (kind_all[g]),
        .q_tag     (tag_all[g]),
        .q_set     (set_all[g]),
        .q_way     (way_all[g]),
        .q_size    (size_all[g]),
        .q_woff    (woff_all[g]),
        .q_boff    (boff_all[g]),
        .q_state   (state_all[g]),
        .q_cnt     (cnt_all[g]),
        .q_word    (word_all[g]),
        .q_line    (line_all[g]),
        .live      (live_vec[g]),
        .cnt_zero  (zero_vec[g])
      );
    end
  endgenerate

  orb_match #(.N(N), .IDX_W(IDX_W), .TAG_W(TAG_W), .SET_W(SET_W)) u_match (
    .mode     (lk_mode),
    .key_tag  (lk_tag),
    .key_set  (lk_set),
    .live_vec (live_vec),
    .tag_all  (tag_all),
    .set_all  (set_all),
    .hit      (lk_hit),
    .hit_idx  (lk_idx)
  );

  assign rd_kind     = kind_all[rd_idx];
  assign rd_tag      = tag_all[rd_idx];
  assign rd_set      = set_all[rd_idx];
  assign rd_way      = way_all[rd_idx];
  assign rd_size     = size_all[rd_idx];
  assign rd_woff     = woff_all[rd_idx];
  assign rd_boff     = boff_all[rd_idx];
  assign rd_state    = state_all[rd_idx];
  assign rd_invack   = cnt_all[rd_idx];
  assign rd_ack_zero = zero_vec[rd_idx];
  assign rd_word     = word_all[rd_idx];
  assign rd_line     = line_all[rd_idx];
endmodule

// File: rtl/orb_table_chk.sv
module orb_table_chk #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_en,
  input logic                    full,
  input logic [IDX_W-1:0]        alloc_idx,
  input logic                    free_en,
  input logic [IDX_W-1:0]        free_idx,
  input logic [1:0]              lk_mode,
  input logic                    lk_hit,
  input logic [IDX_W-1:0]        lk_idx,
  input logic [N-1:0]            live_vec,
  input logic                    ack_load,
  input logic [IDX_W-1:0]        ack_idx,
  input logic [CNT_W-1:0]        ack_val,
  input logic [N-1:0][CNT_W-1:0] cnt_all
);
  // R3: full flag agrees with the live vector of the entries
  a_r3_full_when_no_free: assert property (@(posedge clk) disable iff (!rst_n)
    full == (&live_vec));

  // R2: offered index always names a free entry
  a_r2_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !live_vec[alloc_idx]);

  // R2: an accepted allocation leaves a live entry
  a_r2_alloc_goes_live: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !full && !(free_en && free_idx == alloc_idx))
    |=> live_vec[$past(alloc_idx)]);

  // R7: a freed entry is no longer live
  a_r7_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> !live_vec[$past(free_idx)]);

  // R6: flush lookups never hit
  a_r6_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_mode == 2'd3) |-> !lk_hit);

  // R4 / R5: a hit always names a live entry
  a_r4_hit_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> live_vec[lk_idx]);

  // R9: a load on a live entry that is not being freed takes the value
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_load && live_vec[ack_idx] && !(free_en && free_idx == ack_idx))
    |=> cnt_all[$past(ack_idx)] == $past(ack_val));
endmodule

bind orb_table orb_table_chk #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .alloc_en  (alloc_en),
  .full      (full),
  .alloc_idx (alloc_idx),
  .free_en   (free_en),
  .free_idx  (free_idx),
  .lk_mode   (lk_mode),
  .lk_hit    (lk_hit),
  .lk_idx    (lk_idx),
  .live_vec  (live_vec),
  .ack_load  (ack_load),
  .ack_idx   (ack_idx),
  .ack_val   (ack_val),
  .cnt_all   (cnt_all)
);

// File: tb/test_orb_table.sv
`timescale 1ns/1ps
module test_orb_table;
  localparam int N      = 4;
  localparam int TAG_W  = 16;
  localparam int SET_W  = 8;
  localparam int WAY_W  = 3;
  localparam int WORD_W = 32;
  localparam int LINE_W = 128;
  localparam int CNT_W  = 4;
  localparam int IDX_W  = 2;
  localparam int WOFF_W = 2;
  localparam int BOFF_W = 2;

  logic clk, rst_n;
  logic alloc_en; logic [1:0] alloc_kind; logic [TAG_W-1:0] alloc_tag;
  logic [SET_W-1:0] alloc_set; logic [WAY_W-1:0] alloc_way; logic [1:0] alloc_size;
  logic [WOFF_W-1:0] alloc_woff; logic [BOFF_W-1:0] alloc_boff; logic [3:0] alloc_state;
  logic [WORD_W-1:0] alloc_word; logic [LINE_W-1:0] alloc_line;
  logic [IDX_W-1:0] alloc_idx; logic full;
  logic free_en; logic [IDX_W-1:0] free_idx;
  logic st_we; logic [IDX_W-1:0] st_idx; logic [3:0] st_val;
  logic word_we, line_we; logic [IDX_W-1:0] dat_idx;
  logic [WORD_W-1:0] word_val; logic [LINE_W-1:0] line_val;
  logic ack_load, ack_dec; logic [IDX_W-1:0] ack_idx; logic [CNT_W-1:0] ack_val;
  logic [1:0] lk_mode; logic [TAG_W-1:0] lk_tag; logic [SET_W-1:0] lk_set;
  logic lk_hit; logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] rd_idx; logic [1:0] rd_kind; logic [TAG_W-1:0] rd_tag;
  logic [SET_W-1:0] rd_set; logic [WAY_W-1:0] rd_way; logic [1:0] rd_size;
  logic [WOFF_W-1:0] rd_woff; logic [BOFF_W-1:0] rd_boff; logic [3:0] rd_state;
  logic [CNT_W-1:0] rd_invack; logic rd_ack_zero; logic [WORD_W-1:0] rd_word;
  logic [LINE_W-1:0] rd_line;

  orb_table i_orb_table (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int m_state[N], m_kind[N], m_tag[N], m_set[N], m_way[N], m_size[N];
  int m_woff[N], m_boff[N], m_cnt[N];
  logic [WORD_W-1:0] m_word[N];
  logic [LINE_W-1:0] m_line[N];

  task automatic chk(string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_free_idx();
    for (int i = 0; i < N; i++) if (m_state[i] == 0) return i;
    return 0;
  endfunction

  function automatic bit exp_full();
    for (int i = 0; i < N; i++) if (m_state[i] == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_lookup(output bit h);
    h = 1'b0;
    if (lk_mode == 2'd3) return 0;
    for (int i = 0; i < N; i++)
      if (m_state[i] != 0 && m_set[i] == int'(lk_set) &&
          (lk_mode == 2'd0 || m_tag[i] == int'(lk_tag))) begin
        h = 1'b1;
        return i;
      end
    return 0;
  endfunction

  task automatic check_outputs();
    bit h; int ix; int r;
    chk("R3", "full", LINE_W'(full), LINE_W'(exp_full()));
    if (!exp_full()) chk("R2", "alloc_idx", LINE_W'(alloc_idx), LINE_W'(exp_free_idx()));
    ix = exp_lookup(h);
    case (lk_mode)
      2'd0: chk("R4", "cpu lk_hit", LINE_W'(lk_hit), LINE_W'(h));
      2'd3: chk("R6", "flush lk_hit", LINE_W'(lk_hit), LINE_W'(h));
      default: chk("R5", "tag lk_hit", LINE_W'(lk_hit), LINE_W'(h));
    endcase
    if (h) chk(lk_mode == 2'd0 ? "R4" : "R5", "lk_idx", LINE_W'(lk_idx), LINE_W'(ix));
    r = int'(rd_idx);
    chk("R7/R8", "rd_state", LINE_W'(rd_state), LINE_W'(m_state[r]));
    if (m_state[r] != 0) begin
      chk("R2", "rd_kind", LINE_W'(rd_kind), LINE_W'(m_kind[r]));
      chk("R2", "rd_tag",  LINE_W'(rd_tag),  LINE_W'(m_tag[r]));
      chk("R2", "rd_set",  LINE_W'(rd_set),  LINE_W'(m_set[r]));
      chk("R2", "rd_way",  LINE_W'(rd_way),  LINE_W'(m_way[r]));
      chk("R2", "rd_size", LINE_W'(rd_size), LINE_W'(m_size[r]));
      chk("R2", "rd_woff", LINE_W'(rd_woff), LINE_W'(m_woff[r]));
      chk("R2", "rd_boff", LINE_W'(rd_boff), LINE_W'(m_boff[r]));
      chk("R9", "rd_invack", LINE_W'(rd_invack), LINE_W'(m_cnt[r]));
      chk("R9", "rd_ack_zero", LINE_W'(rd_ack_zero), LINE_W'(m_cnt[r] == 0));
      chk("R10", "rd_word", LINE_W'(rd_word), LINE_W'(m_word[r]));
      chk("R10", "rd_line", rd_line, m_line[r]);
    end
  endtask

  task automatic model_update();
    bit afire; int ai;
    afire = alloc_en && !exp_full();
    ai = exp_free_idx();
    for (int i = 0; i < N; i++) begin
      if (free_en && int'(free_idx) == i) begin
        m_state[i] = 0;
      end else if (afire && ai == i) begin
        m_state[i] = int'(alloc_state); m_kind[i] = int'(alloc_kind);
        m_tag[i] = int'(alloc_tag); m_set[i] = int'(alloc_set);
        m_way[i] = int'(alloc_way); m_size[i] = int'(alloc_size);
        m_woff[i] = int'(alloc_woff); m_boff[i] = int'(alloc_boff);
        m_cnt[i] = 0; m_word[i] = alloc_word; m_line[i] = alloc_line;
      end else begin
        if (st_we && int'(st_idx) == i && m_state[i] != 0) m_state[i] = int'(st_val);
        if (word_we && int'(dat_idx) == i) m_word[i] = word_val;
        if (line_we && int'(dat_idx) == i) m_line[i] = line_val;
        if (ack_load && int'(ack_idx) == i) m_cnt[i] = int'(ack_val);
        else if (ack_dec && int'(ack_idx) == i && m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
      end
    end
  endtask

  task automatic idle_inputs();
    alloc_en = 0; free_en = 0; st_we = 0; word_we = 0; line_we = 0;
    ack_load = 0; ack_dec = 0; lk_mode = 2'd3;
  endtask

  // called just after a falling edge with inputs set
  task automatic cycle();
    #1;
    check_outputs();
    model_update();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_alloc(int tag, int set, int st);
    alloc_en = 1; alloc_kind = 2'($urandom); alloc_tag = TAG_W'(tag);
    alloc_set = SET_W'(set); alloc_way = WAY_W'($urandom); alloc_size = 2'($urandom % 3);
    alloc_woff = WOFF_W'($urandom); alloc_boff = BOFF_W'($urandom);
    alloc_state = 4'(st); alloc_word = $urandom;
    alloc_line = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic random_cycle();
    idle_inputs();
    if ($urandom % 3 == 0) set_alloc($urandom % 4, $urandom % 4, 1 + $urandom % 13);
    free_en = ($urandom % 5 == 0); free_idx = IDX_W'($urandom);
    st_we = ($urandom % 4 == 0); st_idx = IDX_W'($urandom); st_val = 4'(1 + $urandom % 13);
    word_we = ($urandom % 5 == 0); line_we = ($urandom % 5 == 0);
    dat_idx = IDX_W'($urandom); word_val = $urandom;
    line_val = {$urandom, $urandom, $urandom, $urandom};
    ack_load = ($urandom % 5 == 0); ack_dec = ($urandom % 3 == 0);
    ack_idx = IDX_W'($urandom); ack_val = CNT_W'($urandom);
    lk_mode = 2'($urandom); lk_tag = TAG_W'($urandom % 4); lk_set = SET_W'($urandom % 4);
    rd_idx = IDX_W'($urandom);
    cycle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) begin
      m_state[i] = 0; m_cnt[i] = 0;
    end
    idle_inputs();
    alloc_kind = 0; alloc_tag = 0; alloc_set = 0; alloc_way = 0; alloc_size = 0;
    alloc_woff = 0; alloc_boff = 0; alloc_state = 0; alloc_word = 0; alloc_line = 0;
    free_idx = 0; st_idx = 0; st_val = 0; dat_idx = 0; word_val = 0; line_val = 0;
    ack_idx = 0; ack_val = 0; lk_tag = 0; lk_set = 0; rd_idx = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, every lookup mode and every entry
    for (int m = 0; m < 4; m++) begin
      lk_mode = 2'(m); lk_set = 0; lk_tag = 0; rd_idx = IDX_W'(m);
      #1;
      chk("R1", "full", LINE_W'(full), '0);
      chk("R1", "alloc_idx", LINE_W'(alloc_idx), '0);
      chk("R1", "lk_hit", LINE_W'(lk_hit), '0);
      chk("R1", "rd_state", LINE_W'(rd_state), '0);
      @(negedge clk);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    idle_inputs();

    // R2/R3: fill all entries in order, sets 0..3 with tag 8+i
    for (int i = 0; i < N; i++) begin
      set_alloc(8 + i, i, 1 + i);
      rd_idx = IDX_W'(i == 0 ? 0 : i - 1);
      cycle();
    end
    // R3: allocation while full is ignored; verify every entry afterwards
    set_alloc(99, 0, 5);
    cycle();
    for (int i = 0; i < N; i++) begin rd_idx = IDX_W'(i); cycle(); end
    // R4: cpu lookup ignores tag; R5: forward/response need the tag
    lk_mode = 2'd0; lk_set = 2; lk_tag = 77; cycle();
    lk_mode = 2'd1; lk_set = 2; lk_tag = 77; cycle();
    lk_mode = 2'd2; lk_set = 2; lk_tag = 10; cycle();
    lk_mode = 2'd3; lk_set = 2; lk_tag = 10; cycle();
    // R7: free entry 1, it stops matching and is reused
    free_en = 1; free_idx = 1; st_we = 1; st_idx = 1; st_val = 6; cycle();
    lk_mode = 2'd1; lk_set = 1; lk_tag = 9; rd_idx = 1; cycle();
    set_alloc(20, 1, 3); rd_idx = 1; cycle();
    rd_idx = 1; cycle();
    // R8: state write to a free entry is ignored
    free_en = 1; free_idx = 3; cycle();
    st_we = 1; st_idx = 3; st_val = 9; cycle();
    rd_idx = 3; cycle();
    // R9: load, decrement down through zero, load beats decrement
    ack_load = 1; ack_idx = 0; ack_val = 2; rd_idx = 0; cycle();
    for (int k = 0; k < 4; k++) begin ack_dec = 1; ack_idx = 0; rd_idx = 0; cycle(); end
    ack_load = 1; ack_dec = 1; ack_idx = 0; ack_val = 7; rd_idx = 0; cycle();
    rd_idx = 0; cycle();
    // R10: word and line replacement, and allocation precedence
    word_we = 1; line_we = 1; dat_idx = 2; word_val = 32'hCAFE_F00D;
    line_val = {4{32'h1357_9BDF}}; rd_idx = 2; cycle();
    rd_idx = 2; cycle();
    set_alloc(30, 3, 4); word_we = 1; line_we = 1; dat_idx = 3;
    word_val = 32'hDEAD_0000; line_val = '1; cycle();
    rd_idx = 3; cycle();

    for (int n = 0; n < 3000; n++) random_cycle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule